// File: doc/BRIEF.md
# Nibble Bus Flash Read Target

This block is the target end of a 4-bit multiplexed bus that a host uses to fetch single bytes from firmware memory. It watches the shared nibble bus and an active-low frame strobe. When a start nibble marks the beginning of a cycle, the target takes in a device-select nibble, seven address nibbles and a size nibble. If the cycle is meant for it, the target starts the access on a simple request/ready memory port.

After the host's two-clock turn-around, the target takes the bus. It stalls with short-wait SYNC nibbles until enough wait clocks have gone out and the byte has arrived. It then signals ready, returns the byte as two nibbles and hands the bus back to the host. The bus output is split into a value, `bus_o`, and an enable, `bus_oe_o`, so that a pad or a bench can resolve the shared lines. The block never drives the lines during a cycle that was not meant for it.

Top module: `nbt_read_target`

## Requirements
- R1: After reset, `bus_oe_o` and `mem_req_o` are low.
- R2: A cycle begins only on a clock that samples `frame_ni` low with the start nibble 1101b on the bus. With any other nibble under a low frame, the block stays idle. When the frame is low for several clocks, the last one counts.
- R3: The nibble on the first clock after the start must equal parameter `DEV_ID`. Otherwise the block neither drives the bus nor requests memory for the rest of that cycle.
- R4: The next seven nibbles form the 28-bit address, most significant nibble first. `mem_addr_o` holds this value, unchanged, while `mem_req_o` is high.
- R5: The nibble after the address is the size. Any value other than 0000b (one byte) ends the cycle, with no drive and no memory request.
- R6: `mem_req_o` rises on the clock after an accepted size nibble. It stays high until `mem_ready_i` is sampled high, and the byte is taken from `mem_data_i` on that same edge.
- R7: The block does not drive during the host's two turn-around clocks (1111b, then released). `bus_oe_o` first rises on the clock directly after the second one.
- R8: The first driven nibble is a SYNC. The block drives 0101b (wait) each clock until at least `MIN_WAIT` wait nibbles have gone out and the byte has been returned. It then drives 0000b (ready) for one clock. With `MIN_WAIT` = 0 and the byte already back, the first SYNC is 0000b. With a memory that answers L clocks after the request, the number of wait nibbles is max(`MIN_WAIT`, L-1).
- R9: After the ready SYNC, the block drives the byte's low nibble, then its high nibble, on consecutive clocks.
- R10: After the high nibble, the block drives 1111b for one clock and then releases the bus.
- R11: A clock that samples `frame_ni` low aborts any cycle in progress. On the next clock, `bus_oe_o` and `mem_req_o` are low and start detection (R2) applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_ni | input | 1 | Active-low cycle frame strobe from the host |
| bus_i | input | 4 | Resolved nibble bus value |
| bus_o | output | 4 | Nibble driven by the target |
| bus_oe_o | output | 1 | Target drive enable for the nibble bus |
| mem_req_o | output | 1 | Memory read request, held until ready |
| mem_addr_o | output | 28 | Captured byte address |
| mem_ready_i | input | 1 | Memory byte valid |
| mem_data_i | input | 8 | Memory read byte |

## Verification
A state machine that is one step off shows up right at the handoff. `bus_oe_o` rises during the host's turn-around, or a clock late, and the first sampled clock after the turn-around tells the two apart. A wait counter or data latch that is wrong changes how many 0101b nibbles come out, or which nibbles follow the 0000b, within a few clocks of the memory answering. A bad address shift shows on `mem_addr_o` as soon as the request rises. A missed abort leaves the bus driven, or the request high, on the clock after the frame falls.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  typedef logic [NIB_W-1:0] nib_t;

  localparam nib_t SYNC_WAIT = 4'b0101;
  localparam nib_t SYNC_RDY  = 4'b0000;
  localparam nib_t NIB_HIGH  = 4'b1111;
  localparam nib_t SIZE_BYTE = 4'b0000;

  // state names what the next sampled clock carries
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_SIZE,
    ST_TAR1,
    ST_TAR2,
    ST_SYNC,
    ST_DLO,
    ST_DHI,
    ST_HAND
  } state_e;
endpackage

// File: rtl/nbt_addr_shift.sv
module nbt_addr_shift #(
  parameter int NIB_W    = 4,
  parameter int ADDR_NIB = 7,
  localparam int ADDR_W  = NIB_W * ADDR_NIB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  generate
    if (ADDR_NIB == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      addr_q <= '0;
        else if (shift_i) addr_q <= nib_i;
      end
    end else begin : g_shift
      // most significant nibble arrives first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      addr_q <= '0;
        else if (shift_i) addr_q <= {addr_q[ADDR_W-NIB_W-1:0], nib_i};
      end
    end
  endgenerate

  assign addr_o = addr_q;
endmodule

// File: rtl/nbt_sync_ctrl.sv
module nbt_sync_ctrl #(
  parameter int MIN_WAIT = 0,
  parameter int DATA_W   = 8,
  localparam int WCNT_W  = $clog2(MIN_WAIT + 1) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              kill_i,
  input  logic              step_i,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              mem_req_o,
  output logic              go_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam logic [WCNT_W-1:0] WAIT_LIM = WCNT_W'(MIN_WAIT);
  localparam logic [WCNT_W-1:0] WCNT_MAX = '1;

  logic              req_q, vld_q;
  logic [WCNT_W-1:0] wcnt_q;
  logic [DATA_W-1:0] byte_q;
  logic              take, have;

  assign take = req_q & mem_ready_i;
  assign have = vld_q | take;
  assign go_o = have && (wcnt_q >= WAIT_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      vld_q  <= 1'b0;
      wcnt_q <= '0;
      byte_q <= '0;
    end else if (kill_i) begin
      req_q  <= 1'b0;
      vld_q  <= 1'b0;
      wcnt_q <= '0;
    end else if (launch_i) begin
      req_q  <= 1'b1;
      vld_q  <= 1'b0;
      wcnt_q <= '0;
    end else begin
      if (take) begin
        req_q  <= 1'b0;
        vld_q  <= 1'b1;
        byte_q <= mem_data_i;
      end
      if (step_i && !go_o && wcnt_q != WCNT_MAX) wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assign mem_req_o = req_q;
  assign byte_o    = byte_q;
endmodule

// File: rtl/nbt_read_target.sv
module nbt_read_target
  import nbt_pkg::*;
#(
  parameter nib_t DEV_ID     = 4'h0,
  parameter nib_t START_CODE = 4'b1101,
  parameter int   ADDR_NIB   = 7,
  parameter int   MIN_WAIT   = 0,
  localparam int  ADDR_W     = NIB_W * ADDR_NIB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [3:0]        bus_i,
  output logic [3:0]        bus_o,
  output logic              bus_oe_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [7:0]        mem_data_i
);
  localparam int CNT_W = $clog2(ADDR_NIB + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIB - 1);

  state_e            state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  nib_t              out_q, out_n;
  logic              oe_q, oe_n, rdy_q, rdy_n;
  logic              shift, launch, step, kill, go;
  logic [BYTE_W-1:0] byte_w;

  nbt_addr_shift #(.NIB_W(NIB_W), .ADDR_NIB(ADDR_NIB)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .nib_i   (bus_i),
    .addr_o  (mem_addr_o)
  );

  nbt_sync_ctrl #(.MIN_WAIT(MIN_WAIT), .DATA_W(BYTE_W)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .kill_i      (kill),
    .step_i      (step),
    .mem_ready_i (mem_ready_i),
    .mem_data_i  (mem_data_i),
    .mem_req_o   (mem_req_o),
    .go_o        (go),
    .byte_o      (byte_w)
  );

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    out_n   = out_q;
    oe_n    = oe_q;
    rdy_n   = rdy_q;
    shift   = 1'b0;
    launch  = 1'b0;
    step    = 1'b0;
    kill    = 1'b0;
    if (!frame_ni) begin
      // frame low always restarts start detection
      kill    = 1'b1;
      oe_n    = 1'b0;
      rdy_n   = 1'b0;
      out_n   = NIB_HIGH;
      state_n = (bus_i == START_CODE) ? ST_SEL : ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: ;
        ST_SEL: begin
          cnt_n   = '0;
          state_n = (bus_i == DEV_ID) ? ST_ADDR : ST_IDLE;
        end
        ST_ADDR: begin
          shift = 1'b1;
          if (cnt_q == CNT_LAST) state_n = ST_SIZE;
          else                   cnt_n   = cnt_q + 1'b1;
        end
        ST_SIZE: begin
          if (bus_i == SIZE_BYTE) begin
            launch  = 1'b1;
            state_n = ST_TAR1;
          end else begin
            state_n = ST_IDLE;
          end
        end
        ST_TAR1: state_n = ST_TAR2;
        ST_TAR2: begin
          step    = 1'b1;
          oe_n    = 1'b1;
          out_n   = go ? SYNC_RDY : SYNC_WAIT;
          rdy_n   = go;
          state_n = ST_SYNC;
        end
        ST_SYNC: begin
          if (rdy_q) begin
            out_n   = byte_w[3:0];
            rdy_n   = 1'b0;
            state_n = ST_DLO;
          end else begin
            step  = 1'b1;
            out_n = go ? SYNC_RDY : SYNC_WAIT;
            rdy_n = go;
          end
        end
        ST_DLO: begin
          out_n   = byte_w[7:4];
          state_n = ST_DHI;
        end
        ST_DHI: begin
          out_n   = NIB_HIGH;
          state_n = ST_HAND;
        end
        ST_HAND: begin
          oe_n    = 1'b0;
          state_n = ST_IDLE;
        end
        default: begin
          oe_n    = 1'b0;
          state_n = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      out_q   <= NIB_HIGH;
      oe_q    <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      out_q   <= out_n;
      oe_q    <= oe_n;
      rdy_q   <= rdy_n;
    end
  end

  assign bus_o    = out_q;
  assign bus_oe_o = oe_q;
endmodule

// File: rtl/nbt_read_target_chk.sv
module nbt_read_target_chk #(
  parameter int ADDR_W = 28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_ni,
  input logic [3:0]        bus_o,
  input logic              bus_oe_o,
  input logic              mem_req_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o
);
  // R11
  abort_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ni |=> (!bus_oe_o && !mem_req_o));

  // R8
  first_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> (bus_o == 4'b0101 || bus_o == 4'b0000));

  // R10
  handback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bus_oe_o) && $past(frame_ni)) |-> ($past(bus_o) == 4'b1111));

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i && frame_ni) |=> mem_req_o);

  // R4
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> $stable(mem_addr_o));
endmodule

bind nbt_read_target nbt_read_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_ni    (frame_ni),
  .bus_o       (bus_o),
  .bus_oe_o    (bus_oe_o),
  .mem_req_o   (mem_req_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/nbt_read_target_tb.sv
module nbt_read_target_tb;
  localparam logic [3:0] DEV   = 4'h3;
  localparam logic [3:0] START = 4'b1101;
  localparam int         WMIN  = 0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        host_oe = 1'b0;
  logic [3:0]  host_val = 4'hF;
  logic [3:0]  bus, bus_o;
  logic        bus_oe, mem_req;
  logic [27:0] mem_addr, got_addr = '0;
  logic        mem_ready = 1'b0;
  logic [7:0]  mem_data = '0;
  int          mem_lat = 0, lat_cnt = 0, req_cycles = 0;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  // weak pull-up when nobody drives
  assign bus = bus_oe ? bus_o : (host_oe ? host_val : 4'hF);

  nbt_read_target #(.DEV_ID(DEV), .START_CODE(START), .MIN_WAIT(WMIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .bus_i(bus),
    .bus_o(bus_o), .bus_oe_o(bus_oe), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ready_i(mem_ready), .mem_data_i(mem_data));

  function automatic logic [7:0] exp_data(input logic [27:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ {a[27:24], 4'h0} ^ 8'h3C;
  endfunction

  function automatic int exp_waits(input int lat);
    return (lat - 1 > WMIN) ? lat - 1 : WMIN;
  endfunction

  always @(negedge clk) begin
    if (!mem_req) begin
      lat_cnt   <= 0;
      mem_ready <= 1'b0;
    end else if (!mem_ready) begin
      if (lat_cnt == mem_lat) begin
        mem_ready <= 1'b1;
        mem_data  <= exp_data(mem_addr);
        got_addr  <= mem_addr;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  always @(posedge clk) if (mem_req) req_cycles <= req_cycles + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic prefix(input logic [3:0] st, input logic [3:0] sel,
                        input logic [27:0] a, input logic [3:0] sz, input int junk,
                        output bit oe_seen, output bit req_tar);
    oe_seen = 1'b0;
    for (int j = 0; j < junk; j++) begin
      @(negedge clk); oe_seen |= bus_oe;
      frame_n = 1'b0; host_oe = 1'b1; host_val = 4'h7;
    end
    @(negedge clk); oe_seen |= bus_oe;
    frame_n = 1'b0; host_oe = 1'b1; host_val = st;
    @(negedge clk); oe_seen |= bus_oe;
    frame_n = 1'b1; host_val = sel;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); oe_seen |= bus_oe;
      host_val = a[27-4*i -: 4];
    end
    @(negedge clk); oe_seen |= bus_oe; host_val = sz;
    @(negedge clk); oe_seen |= bus_oe; req_tar = mem_req; host_val = 4'hF;
    @(negedge clk); oe_seen |= bus_oe; host_oe = 1'b0;
  endtask

  task automatic run_read(input logic [27:0] a, input int lat, input int junk);
    bit oe_seen, req_tar, ok;
    logic [3:0] nib_s [48];
    bit oe_s [48];
    int w, act_w;
    mem_lat = lat;
    w = exp_waits(lat);
    prefix(START, DEV, a, 4'h0, junk, oe_seen, req_tar);
    chk(!oe_seen, "R7", "drive before turn-around end", oe_seen, 0);
    chk(req_tar, "R6", "request after size", req_tar, 1);
    for (int k = 0; k < w + 5; k++) begin
      @(negedge clk); oe_s[k] = bus_oe; nib_s[k] = bus_o;
    end
    act_w = 0;
    while (act_w < w + 1 && oe_s[act_w] && nib_s[act_w] == 4'b0101) act_w++;
    ok = (act_w == w) && oe_s[w] && nib_s[w] == 4'b0000;
    chk(ok, "R8", "wait nibbles before ready", act_w, w);
    chk(oe_s[w+1] && oe_s[w+2] && {nib_s[w+2], nib_s[w+1]} == exp_data(a),
        "R9", "byte low-then-high", {nib_s[w+2], nib_s[w+1]}, exp_data(a));
    chk(oe_s[w+3] && nib_s[w+3] == 4'hF && !oe_s[w+4], "R10", "handback",
        {oe_s[w+3], nib_s[w+3], oe_s[w+4]}, {1'b1, 4'hF, 1'b0});
    chk(got_addr == a, "R4", "captured address", got_addr, a);
    chk(!mem_req, "R6", "request released", mem_req, 0);
  endtask

  task automatic run_reject(input logic [3:0] st, input logic [3:0] sel,
                            input logic [3:0] sz, input string req);
    bit oe_seen, req_tar;
    int r0;
    r0 = req_cycles;
    prefix(st, sel, 28'h0ABCDEF, sz, 0, oe_seen, req_tar);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); oe_seen |= bus_oe;
    end
    chk(!oe_seen, req, "bus driven on rejected cycle", oe_seen, 0);
    chk(req_cycles == r0, req, "memory requested on rejected cycle", req_cycles - r0, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(!bus_oe && !mem_req, "R1", "outputs in reset", {bus_oe, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_oe && !mem_req, "R1", "outputs after reset", {bus_oe, mem_req}, 0);

    // directed corners
    run_read(28'h0000000, 0, 0);   // R8 immediate ready
    run_read(28'hFFFFFFF, 1, 0);
    run_read(28'h1234567, 6, 2);   // R2 junk frame clocks before start
    run_reject(4'h2, DEV, 4'h0, "R2");
    run_reject(START, DEV ^ 4'h1, 4'h0, "R3");
    run_reject(START, DEV, 4'h1, "R5");

    // R11 abort during SYNC, then recovery
    begin
      bit oe_seen, req_tar;
      mem_lat = 10;
      prefix(START, DEV, 28'h7654321, 4'h0, 0, oe_seen, req_tar);
      repeat (2) @(negedge clk);
      chk(bus_oe && bus_o == 4'b0101, "R8", "wait before abort", bus_o, 4'b0101);
      frame_n = 1'b0;
      @(negedge clk);
      chk(!bus_oe && !mem_req, "R11", "abort release", {bus_oe, mem_req}, 0);
      frame_n = 1'b1;
      @(negedge clk);
    end
    run_read(28'h0C0FFEE, 3, 0);

    for (int t = 0; t < 30; t++)
      run_read(28'($urandom), int'($urandom_range(0, 6)), int'($urandom_range(0, 2)));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule